// File: doc/BRIEF.md
# Shadowed-Update PWM Generator

This block drives one pulse-width-modulated output from a phase accumulator. Software reaches it through a single 32-bit control word. The word holds a step value, a duty threshold, an update request bit and an output enable bit. Step and threshold writes land in shadow fields. The running generator does not see them until software requests an update.

The request bit reads back as a pending flag. The flag clears by itself once the shadow values have been copied into the active set. With the output disabled, the copy happens a fixed synchronisation delay after the request. With the output running, the copy waits for the next period boundary, so that no period is cut short.

Software defines the first activation as follows: program the word, set the request, poll until the flag reads 0, then set enable. A later retune while running needs only the request. Two cases that commonly arise in driver code have defined results: a second request while one is pending, and a read-modify-write of enable that echoes the request bit back. In both cases the pending flag can never stick.

Top module: `pwm_shadow_gen`

## Requirements
- R1: A synchronous active-high reset clears the shadow and active values, the enable bit, the pending flag and the accumulator. After reset, rd_data reads 0 and pwm_out is 0.
- R2: Control word layout for writes and reads: step value in bits 15:0, duty threshold in bits 23:16, update bit 30, enable bit 31. Bits 29:24 read 0. Read bit 30 returns the pending flag. Read bits 23:0 return the shadow values. A write without bit 30 leaves the output waveform unchanged.
- R3: With the output disabled, a write with bit 30 set makes bit 30 read 1 for exactly 4 cycles. In the cycle after that, the flag reads 0 and the shadow values have become active.
- R4: With the output enabled, a pending update waits at least 4 cycles. It then completes on the first cycle in which the accumulator addition overflows 16 bits. If the active step is 0, it completes on the first cycle that is at least 4 cycles after the request.
- R5: While an update is pending, a write with bit 30 set does not restart or extend it, and the step and threshold fields of any write are ignored. The pending update completes on its original schedule.
- R6: Bit 31 of every write is applied, even while an update is pending. A read-modify-write that sets enable while the flag still reads 1 therefore enables the output and does not start a second update.
- R7: While enabled, the 16-bit accumulator adds the active step every clock. pwm_out is 1 exactly when the accumulator's upper 8 bits are below the active threshold.
- R8: When enable is cleared, pwm_out reads 0 from the next cycle on. The accumulator returns to 0, and the active values are kept. A later re-enable restarts the waveform from phase 0.
- R9: A threshold of 0 keeps pwm_out at 0. A threshold of 255 keeps it at 1 except while the upper accumulator byte equals 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback with pending flag |
| pwm_out | output | 1 | PWM output |

## Verification
Two functions can coincide in one cycle: the hardware commit that clears the pending flag, and a software write that carries the update bit. The bench triggers this by sweeping the gap between a first request and a second one over 0 to 6 cycles. The sweep covers writes before, on and after the commit cycle, with the output both disabled and enabled. Each cycle, a cycle-accurate arithmetic model judges the result through the readback and pwm_out. A write that lands on the commit cycle must be dropped, and a write one cycle later must start a fresh update with its own fields.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int ACC_W    = 16;
  localparam int DIV_W    = 8;
  localparam int DATA_W   = 32;
  localparam int SYNC_CYC = 4;
  localparam int CNT_W    = (SYNC_CYC > 2) ? $clog2(SYNC_CYC) : 1;
  localparam int DIV_LSB  = ACC_W;
  localparam int UPD_BIT  = DATA_W - 2;
  localparam int EN_BIT   = DATA_W - 1;
  localparam int PAD_W    = DATA_W - 2 - ACC_W - DIV_W;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [ACC_W-1:0] step;
  } pwm_cfg_t;

  // carry out of the phase addition marks a period boundary
  function automatic logic phase_wraps(logic [ACC_W-1:0] acc, logic [ACC_W-1:0] step);
    logic [ACC_W:0] sum;
    sum = {1'b0, acc} + {1'b0, step};
    return sum[ACC_W];
  endfunction

  function automatic logic duty_high(logic [ACC_W-1:0] acc, logic [DIV_W-1:0] div);
    return acc[ACC_W-1 -: DIV_W] < div;
  endfunction

  function automatic pwm_cfg_t field_of(logic [DATA_W-1:0] word);
    pwm_cfg_t c;
    c.step = word[ACC_W-1:0];
    c.div  = word[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_rd(logic en, logic pend, pwm_cfg_t c);
    return {en, pend, {PAD_W{1'b0}}, c.div, c.step};
  endfunction
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pend,
  output pwm_cfg_t          sh_cfg,
  output logic              en_q,
  output logic              upd_req,
  output logic              upd_drop
);
  logic upd_hit;

  assign upd_hit  = wr_en & wr_data[UPD_BIT];
  assign upd_req  = upd_hit & ~pend;
  assign upd_drop = upd_hit & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      en_q <= wr_data[EN_BIT];
      if (!pend) sh_cfg <= field_of(wr_data);
    end
  end
endmodule

// File: rtl/pwm_update_seq.sv
module pwm_update_seq
  import pwm_shadow_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic upd_req,
  input  logic en_q,
  input  logic boundary,
  output logic pend,
  output logic ready,
  output logic commit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_CYC - 1);
  logic [CNT_W-1:0] cnt_q;

  assign ready  = pend && (cnt_q == LAST);
  assign commit = ready && (!en_q || boundary);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      cnt_q <= '0;
    end else if (upd_req) begin
      pend  <= 1'b1;
      cnt_q <= '0;
    end else if (commit) begin
      pend  <= 1'b0;
      cnt_q <= '0;
    end else if (pend && !ready) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core
  import pwm_shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             commit,
  input  pwm_cfg_t         sh_cfg,
  output pwm_cfg_t         act_cfg,
  output logic [ACC_W-1:0] acc,
  output logic             boundary,
  output logic             pwm_out
);
  assign boundary = en_q && ((act_cfg.step == '0) || phase_wraps(acc, act_cfg.step));
  assign pwm_out  = en_q && duty_high(acc, act_cfg.div);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg <= '0;
      acc     <= '0;
    end else begin
      if (commit) act_cfg <= sh_cfg;
      acc <= en_q ? acc + act_cfg.step : '0;
    end
  end
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);
  pwm_cfg_t         sh_cfg;
  pwm_cfg_t         act_cfg;
  logic             en_q;
  logic             pend;
  logic             ready;
  logic             commit;
  logic             upd_req;
  logic             upd_drop;
  logic             boundary;
  logic [ACC_W-1:0] acc;

  pwm_ctrl_regs regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pend(pend),
    .sh_cfg(sh_cfg), .en_q(en_q), .upd_req(upd_req), .upd_drop(upd_drop)
  );

  pwm_update_seq seq_i (
    .clk(clk), .rst(rst), .upd_req(upd_req), .en_q(en_q), .boundary(boundary),
    .pend(pend), .ready(ready), .commit(commit)
  );

  pwm_phase_core core_i (
    .clk(clk), .rst(rst), .en_q(en_q), .commit(commit), .sh_cfg(sh_cfg),
    .act_cfg(act_cfg), .acc(acc), .boundary(boundary), .pwm_out(pwm_out)
  );

  assign rd_data = pack_rd(en_q, pend, sh_cfg);
endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk
  import pwm_shadow_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input logic             en_q,
  input logic             pend,
  input logic             commit,
  input logic             upd_drop,
  input pwm_cfg_t         sh_cfg,
  input pwm_cfg_t         act_cfg,
  input logic [ACC_W-1:0] acc
);
  logic [7:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (!pend) age_q <= '0;
    else if (age_q != 8'hFF) age_q <= age_q + 1'b1;
  end

  p_min_delay_r3: assert property (@(posedge clk) disable iff (rst)
    commit |-> (age_q >= 8'(SYNC_CYC - 1)));

  p_commit_clears_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> !pend);

  p_copy_on_commit_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (act_cfg == $past(sh_cfg)));

  p_pend_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && !commit) |=> pend);

  p_drop_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_drop && commit) |=> !pend);

  p_shadow_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    pend |=> $stable(sh_cfg));

  p_acc_step_r7: assert property (@(posedge clk) disable iff (rst)
    en_q |=> (acc == $past(acc) + $past(act_cfg.step)));

  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !pwm_out);

  p_acc_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (acc == '0));

  p_active_kept_r8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_cfg));
endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk chk_i (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .en_q(en_q), .pend(pend),
  .commit(commit), .upd_drop(upd_drop), .sh_cfg(sh_cfg), .act_cfg(act_cfg), .acc(acc)
);

// File: tb/pwm_shadow_gen_tb.sv
module pwm_shadow_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference model state
  logic [15:0] m_step, m_astep, m_acc;
  logic [7:0]  m_div, m_adiv;
  logic        m_en, m_pend;
  int          m_cnt;

  always #2 clk = ~clk;

  pwm_shadow_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] mk(logic en, logic upd, logic [7:0] div, logic [15:0] step);
    return {en, upd, 6'b0, div, step};
  endfunction

  task automatic model_reset();
    m_step = 0; m_astep = 0; m_acc = 0; m_div = 0; m_adiv = 0;
    m_en = 0; m_pend = 0; m_cnt = 0;
  endtask

  task automatic model_edge(input logic we, input logic [31:0] d);
    logic [16:0] sum;
    logic        bnd, com;
    logic        old_pend;
    sum = {1'b0, m_acc} + {1'b0, m_astep};
    bnd = m_en && (m_astep == 0 || sum[16]);
    com = m_pend && (m_cnt == 3) && (!m_en || bnd);
    old_pend = m_pend;
    m_acc = m_en ? sum[15:0] : 16'h0;
    if (com) begin m_astep = m_step; m_adiv = m_div; end
    if (we && d[30] && !old_pend) begin m_pend = 1; m_cnt = 0; end
    else if (com) begin m_pend = 0; m_cnt = 0; end
    else if (m_pend && m_cnt < 3) m_cnt = m_cnt + 1;
    if (we) begin
      m_en = d[31];
      if (!old_pend) begin m_step = d[15:0]; m_div = d[23:16]; end
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] exp_rd;
    logic        exp_pwm;
    exp_rd  = {m_en, m_pend, 6'b0, m_div, m_step};
    exp_pwm = m_en && (m_acc[15:8] < m_adiv);
    vectors++;
    if (rd_data !== exp_rd || pwm_out !== exp_pwm) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h, pwm_out=%b expected %b",
               tag, rd_data, exp_rd, pwm_out, exp_pwm);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic cyc(input logic we, input logic [31:0] d, input string tag);
    wr_en = we; wr_data = d;
    @(posedge clk);
    model_edge(we, d);
    @(negedge clk);
    wr_en = 0; wr_data = '0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, '0, tag);
  endtask

  task automatic wait_clear(input string tag);
    for (int i = 0; i < 400 && rd_data[30]; i++) cyc(0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] steps [4];
    logic [7:0]  divs  [4];
    steps = '{16'h0100, 16'h1000, 16'h0333, 16'hFFFF};
    divs  = '{8'd0, 8'd1, 8'd128, 8'd255};
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1 reset state");
    idle(2, "R1 reset idle");

    // R2: shadow write, no update, no effect on output
    cyc(1, mk(0, 0, 8'h5A, 16'h1234), "R2 layout readback");
    cyc(1, mk(1, 0, 8'h5A, 16'h1234), "R2 enable without update");
    idle(40, "R2 waveform unchanged");
    cyc(1, mk(0, 0, 8'h5A, 16'h1234), "R8 disable");

    // R3: update while disabled, flag exactly 4 cycles
    cyc(1, mk(0, 1, 8'h40, 16'h0800), "R3 request");
    idle(6, "R3 self-clear timing");

    // R7/R9: sweep step x threshold from first activation
    foreach (steps[i]) foreach (divs[j]) begin
      cyc(1, mk(0, 0, 8'h0, 16'h0), "R8 disable before sweep");
      cyc(1, mk(0, 1, divs[j], steps[i]), "R3 sweep request");
      wait_clear("R3 sweep poll");
      cyc(1, mk(1, 0, divs[j], steps[i]), "R7 activation");
      idle(280, (divs[j] == 0 || divs[j] == 255) ? "R9 threshold limits" : "R7 duty waveform");
    end

    // R4: dynamic update while enabled, waits for boundary
    cyc(1, mk(1, 1, 8'd30, 16'h0700), "R4 live update");
    idle(200, "R4 boundary commit");
    cyc(1, mk(1, 1, 8'd90, 16'h0000), "R4 update to zero step");
    idle(20, "R4 zero step run");
    cyc(1, mk(1, 1, 8'd200, 16'h0400), "R4 update from zero step");
    idle(100, "R4 leave zero step");

    // R5/R6: collision sweep of a second request against the commit cycle
    for (int en = 0; en < 2; en++) begin
      for (int off = 0; off < 7; off++) begin
        cyc(1, mk(en[0], 1, 8'd100, 16'h2000), "R5 first request");
        idle(off, "R5 gap");
        cyc(1, mk(en[0], 1, 8'd10, 16'h0900), en ? "R6 echo with enable" : "R5 second request");
        wait_clear("R5 completion");
        idle(70, "R5 settle");
      end
    end

    // R6: read-modify-write race for first activation
    cyc(1, mk(0, 0, 8'h0, 16'h0), "R8 disable");
    cyc(1, mk(0, 1, 8'd64, 16'h0300), "R6 request");
    cyc(1, mk(1, 1, 8'd64, 16'h0300), "R6 rmw enable");
    idle(300, "R6 run after race");

    // R8: disable keeps active values, re-enable from phase 0
    cyc(1, mk(0, 0, 8'd64, 16'h0300), "R8 disable");
    idle(5, "R8 held low");
    cyc(1, mk(1, 0, 8'd64, 16'h0300), "R8 re-enable");
    idle(300, "R8 restart");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule